// File: doc/BRIEF.md
# Chainable Serial Input Register for a 16-bit DAC

This block receives DAC codes over a three-wire synchronous serial link: a data line, a bit clock and a load strobe. All three lines are treated as asynchronous to the system clock. Each is resynchronised, and rising edges are detected inside the system clock domain. Bits enter a shift register most significant bit first, one per rising edge of the bit clock. A rising edge of the load strobe copies the whole shift register in parallel into the holding register that feeds the converter.

The bit that falls off the far end of the shift register is driven on a serial output. Several of these blocks can therefore be wired in a chain, output to data input, with a common bit clock and a common strobe. The chain then behaves as one long shift register. A clear input and a two-bit span selector complete the interface. Clear raises a "bottom of span" flag, and the downstream converter uses that flag in place of the stored code. Clear changes neither the holding register nor the shift register. The flag drops only at the next load.

Top module: `sdac_in_reg`

## Requirements
- R1: After reset, `code_o` is 0, `bottom_o` is 1, `sdo_o` is 0 and `span_o` is 0.
- R2: Each rising edge of `sclk_i` shifts `sdi_i` into bit 0 of the shift register, with older bits moving toward bit 15. After 16 edges, the first bit sent sits in bit 15.
- R3: A rising edge of `load_i` copies the shift register into `code_o` and clears `bottom_o`. At all other times `code_o` holds, including while bits are shifted in.
- R4: Loading is edge-triggered. Holding `load_i` high while more bits are shifted in does not change `code_o`.
- R5: `sdo_o` always equals bit 15 of the shift register. It changes only after a shifting edge, so a following device samples a settled bit at its next rising `sclk_i`.
- R6: In a chain of two blocks that share `sclk_i` and `load_i`, after 32 bits the first 16 bits sent are loaded into the far block and the last 16 into the near block.
- R7: While `clear_i` is high, `bottom_o` is 1. It stays 1 after `clear_i` falls and drops only at the next load. `code_o` and the shift register keep their contents.
- R8: A load edge that arrives while `clear_i` is high is ignored. A load edge after clear is released restores normal output from the shift register.
- R9: `span_o` follows `span_sel_i` one clock later. The codes are: 00 = 0–5 V, 01 = 4–20 mA, 10 = 0–20 mA, 11 = 0–24 mA. The span selection does not affect `code_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sdi_i | input | 1 | Serial data in |
| sclk_i | input | 1 | Serial bit clock |
| load_i | input | 1 | Load strobe; its rising edge transfers the word |
| clear_i | input | 1 | Force output to bottom of span |
| span_sel_i | input | 2 | Span selection |
| sdo_o | output | 1 | Serial data out toward the next device in the chain |
| code_o | output | 16 | DAC code held for the converter |
| span_o | output | 2 | Registered span selection |
| bottom_o | output | 1 | Output-at-bottom-of-span flag |

## Verification
A corrupted shift register shows up on `sdo_o` within one bit time, because that output is the register's top bit. It also shows up in full on `code_o` after the next load. A load-enable fault shows up as a `code_o` change during shifting, or as a missed change after a strobe edge. These appear three system clocks after the relevant serial edge. Clear faults appear as a wrong `bottom_o` one cycle after `clear_i` rises, or as a lost code after clear is released. A chain of two devices exposes off-by-one errors in shift direction and in output timing.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int CODE_W_DEF  = 16;
  localparam int SYNC_N_DEF  = 2;
  localparam int SPAN_W      = 2;

  typedef enum logic [SPAN_W-1:0] {
    SPAN_V_0_5   = 2'b00,
    SPAN_I_4_20  = 2'b01,
    SPAN_I_0_20  = 2'b10,
    SPAN_I_0_24  = 2'b11
  } span_e;

  // serial channel indices into the synchroniser bank
  localparam int CH_SDI  = 0;
  localparam int CH_SCLK = 1;
  localparam int CH_LOAD = 2;
  localparam int N_CH    = 3;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], din};
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] q,
  output logic             sout
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_en) q <= {q[WIDTH-2:0], din};
  end

  assign sout = q[WIDTH-1];
endmodule

// File: rtl/sdac_hold.sv
module sdac_hold #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load_en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] code,
  output logic             bottom
);
  logic take;
  assign take = load_en && !clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      code   <= '0;
      bottom <= 1'b1;
    end else begin
      if (take) code <= d;
      if (clear)     bottom <= 1'b1;
      else if (take) bottom <= 1'b0;
    end
  end
endmodule

// File: rtl/sdac_in_reg.sv
module sdac_in_reg
  import sdac_pkg::*;
#(
  parameter int CODE_W = CODE_W_DEF,
  parameter int SYNC_N = SYNC_N_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdi_i,
  input  logic              sclk_i,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [1:0]        span_sel_i,
  output logic              sdo_o,
  output logic [CODE_W-1:0] code_o,
  output logic [1:0]        span_o,
  output logic              bottom_o
);
  logic [N_CH-1:0] raw, synced, prev;
  logic            sclk_rise, load_rise;
  logic [CODE_W-1:0] shift_q;

  assign raw[CH_SDI]  = sdi_i;
  assign raw[CH_SCLK] = sclk_i;
  assign raw[CH_LOAD] = load_i;

  for (genvar g = 0; g < N_CH; g++) begin : g_sync
    sdac_sync #(.STAGES(SYNC_N)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (raw[g]),
      .dout(synced[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= synced;
  end

  assign sclk_rise = synced[CH_SCLK] && !prev[CH_SCLK];
  assign load_rise = synced[CH_LOAD] && !prev[CH_LOAD];

  sdac_shift #(.WIDTH(CODE_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .shift_en(sclk_rise),
    .din     (synced[CH_SDI]),
    .q       (shift_q),
    .sout    (sdo_o)
  );

  sdac_hold #(.WIDTH(CODE_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .clear  (clear_i),
    .load_en(load_rise),
    .d      (shift_q),
    .code   (code_o),
    .bottom (bottom_o)
  );

  always_ff @(posedge clk) begin
    if (rst) span_o <= SPAN_V_0_5;
    else     span_o <= span_sel_i;
  end
endmodule

// File: rtl/sdac_in_reg_chk.sv
module sdac_in_reg_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             clear_i,
  input logic [1:0]       span_sel_i,
  input logic             sdo_o,
  input logic [WIDTH-1:0] code_o,
  input logic [1:0]       span_o,
  input logic             bottom_o,
  input logic             shift_evt,
  input logic             load_evt,
  input logic [WIDTH-1:0] shift_q
);
  AST_SHIFT_INTO_SDO: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> sdo_o == $past(shift_q[WIDTH-2])); // R2
  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (rst)
    !shift_evt |=> $stable(sdo_o)); // R5
  AST_LOAD_TAKES_WORD: assert property (@(posedge clk) disable iff (rst)
    (load_evt && !clear_i) |=> (code_o == $past(shift_q)) && !bottom_o); // R3
  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> $stable(code_o)); // R4
  AST_CLEAR_BOTTOM: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> bottom_o && $stable(code_o)); // R7
  AST_CLEAR_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (clear_i && load_evt) |=> $stable(code_o)); // R8
  AST_SPAN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> span_o == $past(span_sel_i)); // R9
endmodule

bind sdac_in_reg sdac_in_reg_chk #(.WIDTH(CODE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clear_i   (clear_i),
  .span_sel_i(span_sel_i),
  .sdo_o     (sdo_o),
  .code_o    (code_o),
  .span_o    (span_o),
  .bottom_o  (bottom_o),
  .shift_evt (sclk_rise),
  .load_evt  (load_rise),
  .shift_q   (shift_q)
);

// File: tb/tb_sdac_in_reg.sv
`timescale 1ns/1ps
module tb_sdac_in_reg;
  localparam int W = 16;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdi = 1'b0, sclk = 1'b0, load = 1'b0, clr = 1'b0;
  logic [1:0] span_sel = 2'b00;
  logic sdo, far_sdo, bottom, far_bottom;
  logic [W-1:0] code, far_code;
  logic [1:0] span, far_span;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sdac_in_reg dut (
    .clk(clk), .rst(rst), .sdi_i(sdi), .sclk_i(sclk), .load_i(load),
    .clear_i(clr), .span_sel_i(span_sel), .sdo_o(sdo), .code_o(code),
    .span_o(span), .bottom_o(bottom)
  );

  sdac_in_reg u_far (
    .clk(clk), .rst(rst), .sdi_i(sdo), .sclk_i(sclk), .load_i(load),
    .clear_i(1'b0), .span_sel_i(2'b00), .sdo_o(far_sdo), .code_o(far_code),
    .span_o(far_span), .bottom_o(far_bottom)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b;    wait_clk(HOLD);
    sclk = 1'b1; wait_clk(HOLD);
    sclk = 1'b0; wait_clk(HOLD);
  endtask

  task automatic send_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_load();
    load = 1'b1; wait_clk(HOLD);
    load = 1'b0; wait_clk(HOLD);
  endtask

  task automatic t_reset();
    check(code == 0, "R1 code", code, 0);
    check(bottom == 1'b1, "R1 bottom", bottom, 1);
    check(sdo == 1'b0, "R1 sdo", sdo, 0);
    check(span == 2'b00, "R1 span", span, 0);
  endtask

  task automatic t_shift_load();
    send_word(16'hA5C3);
    check(code == 0, "R3 code held during shift", code, 0);
    check(sdo == 1'b1, "R5 sdo is word msb", sdo, 1);
    pulse_load();
    check(code == 16'hA5C3, "R2 word loaded msb first", code, 16'hA5C3);
    check(bottom == 1'b0, "R3 bottom cleared by load", bottom, 0);
    send_bit(1'b0);
    check(sdo == 1'b0, "R5 sdo after one shift", sdo, 0);
    send_bit(1'b1);
    check(sdo == 1'b1, "R5 sdo after two shifts", sdo, 1);
  endtask

  task automatic t_edge_load();
    send_word(16'h1234);
    pulse_load();
    load = 1'b1; wait_clk(HOLD);
    check(code == 16'h1234, "R4 load rise", code, 16'h1234);
    send_word(16'h5678);
    check(code == 16'h1234, "R4 level high ignored", code, 16'h1234);
    load = 1'b0; wait_clk(HOLD);
    pulse_load();
    check(code == 16'h5678, "R4 next edge loads", code, 16'h5678);
  endtask

  task automatic t_chain();
    send_word(16'hC0DE);
    send_word(16'h0FF1);
    pulse_load();
    check(far_code == 16'hC0DE, "R6 far gets first word", far_code, 16'hC0DE);
    check(code == 16'h0FF1, "R6 near gets last word", code, 16'h0FF1);
  endtask

  task automatic t_clear();
    send_word(16'hBEEF);
    clr = 1'b1; wait_clk(HOLD);
    check(bottom == 1'b1, "R7 bottom while clear", bottom, 1);
    check(code == 16'h0FF1, "R7 code kept", code, 16'h0FF1);
    clr = 1'b0; wait_clk(HOLD);
    check(bottom == 1'b1, "R7 bottom after release", bottom, 1);
    pulse_load();
    check(code == 16'hBEEF, "R7 shift reg untouched", code, 16'hBEEF);
    check(bottom == 1'b0, "R8 load restores output", bottom, 0);
    send_word(16'h0F0F);
    clr = 1'b1; wait_clk(HOLD);
    pulse_load();
    check(code == 16'hBEEF, "R8 load ignored in clear", code, 16'hBEEF);
    check(bottom == 1'b1, "R8 bottom kept in clear", bottom, 1);
    clr = 1'b0; wait_clk(HOLD);
    pulse_load();
    check(code == 16'h0F0F, "R8 load after clear", code, 16'h0F0F);
    check(bottom == 1'b0, "R8 bottom drops", bottom, 0);
  endtask

  task automatic t_span();
    for (int s = 0; s < 4; s++) begin
      span_sel = 2'(s);
      wait_clk(2);
      check(span == 2'(s), "R9 span mirror", span, s);
      check(code == 16'h0F0F, "R9 code unaffected", code, 16'h0F0F);
    end
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    t_reset();
    t_shift_load();
    t_edge_load();
    t_chain();
    t_clear();
    t_span();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule